// File: doc/BRIEF.md
# Reloadable Timer Bank with Free-Running Counter

This block is a memory-mapped timer peripheral on a plain register bus: an address, a write strobe, write data, and read data that is decoded combinationally from the current state. It holds three down-counting channels and one wide up-counter. Channels 1 and 2 are 16 bits wide and channel 3 is 32 bits wide. Each channel has its own load, value, control and clear registers and its own interrupt line. Two tick-enable inputs, a slow one and a fast one, stand in for two prescaled clocks. Each channel selects one of them.

Software sets up a channel in three writes: first the control word with the channel disabled, then the load value, then the control word again with the enable bit set. In periodic mode a channel reloads from its load register when it underflows, so an underflow repeats every load+1 ticks. In wrap mode it rolls over to all ones. Every underflow latches the channel's interrupt, and the interrupt stays set until software writes any value to that channel's clear register.

The 40-bit free-running counter counts fast ticks and never interrupts. Its low 32 bits and its top bits are read from two separate registers, and its run enable sits in the high register.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every channel's load, value and control register reads 0, all interrupts are low, the high register of the free counter reads 0 and its low register reads the low 32 bits of the FREE_INIT parameter.
- R2: Channels sit at base addresses 0x00, 0x20 and 0x80. Within a channel, offset +0x0 is load (read/write), +0x4 is value (read-only), +0x8 is control and +0xC is clear. The free counter's low word is at 0x60 and its high register is at 0x64. Any other address reads 0.
- R3: In the control register, bit 7 is enable, bit 6 selects periodic reload, and bit 3 selects the fast tick (when clear, the slow tick is used). All other control bits read 0. A channel decrements only on the edges where it is enabled and its selected tick input is high.
- R4: A load write while the channel is disabled also copies the value into the counter. A load write while the channel is enabled changes only the load register.
- R5: In periodic mode, a counter at 0 that receives a tick reloads from the load register, so underflows are spaced load+1 ticks apart.
- R6: In wrap mode, a counter at 0 that receives a tick becomes all ones of its own width (0xFFFF for channels 1 and 2, 0xFFFFFFFF for channel 3).
- R7: Each underflow sets that channel's interrupt (irq bit 0 for channel 1, bit 1 for channel 2, bit 2 for channel 3). The interrupt stays set until a write of any value to the channel's clear register drops it.
- R8: When an underflow and a clear write to the same channel fall on the same edge, the interrupt stays set.
- R9: Writes to a value register are ignored.
- R10: The free counter adds one on each fast tick while bit 8 of its high register is set. Slow ticks have no effect on it, and writes to the low word are ignored. The high register returns count bits 39:32 in bits 7:0 and the enable in bit 8.
- R11: A carry out of the low 32 bits of the free counter increments the bits returned in the high register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSlow | input | 1 | Slow tick enable |
| tickFast | input | 1 | Fast tick enable, also drives the free counter |
| busAddr | input | 8 | Register byte address |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irq | output | 3 | Per-channel pending interrupt |

## Verification
A channel's underflow and a software clear of the same channel's interrupt can land on the same clock edge. The bench provokes this by counting channel 1 down to zero and then issuing the clear write in the same cycle as the fast tick that underflows it. The irq line must still be set afterwards, and a plain clear write afterwards must drop it. Similarly, a load write on a running channel is placed between ticks, and the value register must be unchanged while the load register reads back the new value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NCH = 3;

  localparam logic [3:0] OFF_LOAD  = 4'h0;
  localparam logic [3:0] OFF_VALUE = 4'h4;
  localparam logic [3:0] OFF_CTRL  = 4'h8;
  localparam logic [3:0] OFF_CLEAR = 4'hC;
  localparam logic [7:0] FREE_LO_ADDR = 8'h60;
  localparam logic [7:0] FREE_HI_ADDR = 8'h64;

  localparam int CTRL_EN_BIT   = 7;
  localparam int CTRL_PER_BIT  = 6;
  localparam int CTRL_FAST_BIT = 3;
  localparam int FREE_EN_BIT   = 8;

  typedef struct packed {
    logic [NCH-1:0] loadWr;
    logic [NCH-1:0] ctrlWr;
    logic [NCH-1:0] clrWr;
    logic           freeCfgWr;
  } tmrStrobe_t;

  function automatic logic [7:0] regAddr(input int ch, input logic [3:0] off);
    logic [7:0] base;
    case (ch)
      0:       base = 8'h00;
      1:       base = 8'h20;
      default: base = 8'h80;
    endcase
    return base | {4'h0, off};
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickSlow,
  input  logic             tickFast,
  input  logic             loadWr,
  input  logic             ctrlWr,
  input  logic             clrWr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [2:0]       ctrlIn,   // {enable, periodic, fast}
  output logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             ctrlEn,
  output logic             ctrlPer,
  output logic             ctrlFast,
  output logic             irq
);
  logic tickSel;
  logic step;
  logic underflow;

  assign tickSel   = ctrlFast ? tickFast : tickSlow;
  assign step      = ctrlEn && tickSel;
  assign underflow = step && (cntVal == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadVal  <= '0;
      cntVal   <= '0;
      ctrlEn   <= 1'b0;
      ctrlPer  <= 1'b0;
      ctrlFast <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrlEn   <= ctrlIn[2];
        ctrlPer  <= ctrlIn[1];
        ctrlFast <= ctrlIn[0];
      end
      if (loadWr) loadVal <= wdata;
      if (step) begin
        if (underflow) cntVal <= ctrlPer ? loadVal : '1;
        else           cntVal <= cntVal - 1'b1;
      end else if (loadWr && !ctrlEn) begin
        cntVal <= wdata;
      end
      // a new underflow outranks a clear landing on the same edge
      if (underflow)  irq <= 1'b1;
      else if (clrWr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath import tmr_pkg::*; #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40,
  parameter logic [FREE_W-1:0] FREE_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] chLoad [NCH],
  output logic [DATA_W-1:0] chCnt  [NCH],
  output logic [DATA_W-1:0] chCtrl [NCH],
  output logic [NCH-1:0]    irq,
  output logic [FREE_W-1:0] freeCnt,
  output logic              freeEn
);
  logic [2:0] ctrlIn;
  assign ctrlIn = {wdata[CTRL_EN_BIT], wdata[CTRL_PER_BIT], wdata[CTRL_FAST_BIT]};

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam int W = (i == NCH - 1) ? WIDE_W : NARROW_W;
    logic [W-1:0] ldQ;
    logic [W-1:0] cntQ;
    logic         en;
    logic         per;
    logic         fast;

    tmr_chan #(.CNT_W(W)) u_chan (
      .clk      (clk),
      .rstN     (rstN),
      .tickSlow (tickSlow),
      .tickFast (tickFast),
      .loadWr   (strobe.loadWr[i]),
      .ctrlWr   (strobe.ctrlWr[i]),
      .clrWr    (strobe.clrWr[i]),
      .wdata    (wdata[W-1:0]),
      .ctrlIn   (ctrlIn),
      .loadVal  (ldQ),
      .cntVal   (cntQ),
      .ctrlEn   (en),
      .ctrlPer  (per),
      .ctrlFast (fast),
      .irq      (irq[i])
    );

    assign chLoad[i] = DATA_W'(ldQ);
    assign chCnt[i]  = DATA_W'(cntQ);
    // readback places enable, periodic and fast at bits 7, 6 and 3
    assign chCtrl[i] = DATA_W'({en, per, 2'b00, fast, 3'b000});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeCnt <= FREE_INIT;
      freeEn  <= 1'b0;
    end else begin
      if (strobe.freeCfgWr) freeEn <= wdata[FREE_EN_BIT];
      if (freeEn && tickFast) freeCnt <= freeCnt + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_regctl.sv
module tmr_regctl import tmr_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int FREE_W = 40
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] chLoad [NCH],
  input  logic [DATA_W-1:0] chCnt  [NCH],
  input  logic [DATA_W-1:0] chCtrl [NCH],
  input  logic [FREE_W-1:0] freeCnt,
  input  logic              freeEn,
  output tmrStrobe_t        strobe,
  output logic [DATA_W-1:0] busRdata
);
  localparam int HI_W = FREE_W - DATA_W;

  always_comb begin
    strobe = '0;
    if (busWe) begin
      for (int i = 0; i < NCH; i++) begin
        if (busAddr == ADDR_W'(regAddr(i, OFF_LOAD)))  strobe.loadWr[i] = 1'b1;
        if (busAddr == ADDR_W'(regAddr(i, OFF_CTRL)))  strobe.ctrlWr[i] = 1'b1;
        if (busAddr == ADDR_W'(regAddr(i, OFF_CLEAR))) strobe.clrWr[i]  = 1'b1;
      end
      if (busAddr == ADDR_W'(FREE_HI_ADDR)) strobe.freeCfgWr = 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (busAddr == ADDR_W'(regAddr(i, OFF_LOAD)))  busRdata = chLoad[i];
      if (busAddr == ADDR_W'(regAddr(i, OFF_VALUE))) busRdata = chCnt[i];
      if (busAddr == ADDR_W'(regAddr(i, OFF_CTRL)))  busRdata = chCtrl[i];
    end
    if (busAddr == ADDR_W'(FREE_LO_ADDR)) busRdata = freeCnt[DATA_W-1:0];
    if (busAddr == ADDR_W'(FREE_HI_ADDR)) begin
      busRdata[HI_W-1:0]   = freeCnt[FREE_W-1:DATA_W];
      busRdata[FREE_EN_BIT] = freeEn;
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank import tmr_pkg::*; #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32,
  parameter int FREE_W   = 40,
  parameter logic [FREE_W-1:0] FREE_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [NCH-1:0]    irq
);
  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] chLoad [NCH];
  logic [DATA_W-1:0] chCnt  [NCH];
  logic [DATA_W-1:0] chCtrl [NCH];
  logic [FREE_W-1:0] freeCnt;
  logic              freeEn;

  tmr_regctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FREE_W(FREE_W)) u_regctl (
    .busAddr  (busAddr),
    .busWe    (busWe),
    .chLoad   (chLoad),
    .chCnt    (chCnt),
    .chCtrl   (chCtrl),
    .freeCnt  (freeCnt),
    .freeEn   (freeEn),
    .strobe   (strobe),
    .busRdata (busRdata)
  );

  tmr_datapath #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W),
    .FREE_W(FREE_W), .FREE_INIT(FREE_INIT)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tickSlow (tickSlow),
    .tickFast (tickFast),
    .strobe   (strobe),
    .wdata    (busWdata),
    .chLoad   (chLoad),
    .chCnt    (chCnt),
    .chCtrl   (chCtrl),
    .irq      (irq),
    .freeCnt  (freeCnt),
    .freeEn   (freeEn)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker import tmr_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int FREE_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickSlow,
  input logic              tickFast,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [NCH-1:0]    irq,
  input logic [FREE_W-1:0] freeCnt,
  input logic              freeEn
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic clrHit;
    assign clrHit = busWe && (busAddr == ADDR_W'(regAddr(c, OFF_CLEAR)));

    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] && !clrHit |=> irq[c]);

    p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
      clrHit && !tickFast && !tickSlow |=> !irq[c]);

    p_irq_needs_tick_r3: assert property (@(posedge clk) disable iff (!rstN)
      !irq[c] && !tickFast && !tickSlow |=> !irq[c]);
  end

  p_free_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    freeEn && tickFast |=> freeCnt == $past(freeCnt) + 1'b1);

  p_free_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !tickFast |=> $stable(freeCnt));

  p_free_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    !freeEn |=> $stable(freeCnt));
endmodule

bind tick_timer_bank tmr_checker #(.ADDR_W(ADDR_W), .FREE_W(FREE_W)) u_tmrChecker (
  .clk      (clk),
  .rstN     (rstN),
  .tickSlow (tickSlow),
  .tickFast (tickFast),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .irq      (irq),
  .freeCnt  (freeCnt),
  .freeEn   (freeEn)
);

// File: tb/test_tick_timer_bank.sv
module test_tick_timer_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickSlow = 1'b0;
  logic        tickFast = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  irq;

  int checkCnt = 0;
  int errCnt = 0;
  bit finished = 0;

  logic [31:0] qExp [$];
  bit          qIsIrq [$];
  string       qTag [$];

  always #5 clk = ~clk;

  tick_timer_bank #(.FREE_INIT(40'h00_FFFF_FFFC)) i_tick_timer_bank (
    .clk(clk), .rstN(rstN), .tickSlow(tickSlow), .tickFast(tickFast),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  // driver side: each task holds its stimulus for one clock
  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tf = 1'b0);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; tickFast = tf;
    @(posedge clk); #1;
    busWe = 1'b0; tickFast = 1'b0;
  endtask

  task automatic tick(input bit fast, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (fast) tickFast = 1'b1; else tickSlow = 1'b1;
      @(posedge clk); #1;
      tickFast = 1'b0; tickSlow = 1'b0;
    end
  endtask

  task automatic expectRd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busAddr = a; busWe = 1'b0;
    #1;
    qExp.push_back(e); qIsIrq.push_back(1'b0); qTag.push_back(tag);
  endtask

  task automatic expectIrq(input logic [2:0] e, input string tag);
    @(negedge clk);
    #1;
    qExp.push_back({29'b0, e}); qIsIrq.push_back(1'b1); qTag.push_back(tag);
  endtask

  // monitor side: compares queued expectations mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (qExp.size() > 0) begin
        logic [31:0] e;
        logic [31:0] act;
        bit          isIrq;
        string       tag;
        e = qExp.pop_front(); isIrq = qIsIrq.pop_front(); tag = qTag.pop_front();
        act = isIrq ? {29'b0, irq} : busRdata;
        checkCnt++;
        if (act !== e) begin
          errCnt++;
          $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    expectRd(8'h00, 32'h0, "R1 ch1 load");
    expectRd(8'h04, 32'h0, "R1 ch1 value");
    expectRd(8'h08, 32'h0, "R1 ch1 ctrl");
    expectRd(8'h64, 32'h0, "R1 free high");
    expectRd(8'h60, 32'hFFFF_FFFC, "R1 free low");
    expectIrq(3'b000, "R1 irq");

    // channel 1: periodic, fast tick, load 4
    wr(8'h08, 32'h48);
    wr(8'h00, 32'd4);
    expectRd(8'h04, 32'd4, "R4 disabled load copies");
    expectRd(8'h08, 32'h48, "R3 ctrl readback");
    wr(8'h08, 32'hFF);
    expectRd(8'h08, 32'hC8, "R3 only bits 7,6,3 kept");
    tick(0, 3);
    expectRd(8'h04, 32'd4, "R3 slow tick ignored");
    tick(1, 4);
    expectRd(8'h04, 32'd0, "R5 at zero");
    expectIrq(3'b000, "R5 no irq before load+1");
    tick(1, 1);
    expectIrq(3'b001, "R5 irq at load+1");
    expectRd(8'h04, 32'd4, "R5 reload");
    tick(1, 4);
    expectIrq(3'b001, "R7 irq sticky");
    expectRd(8'h04, 32'd0, "R5 second period");
    wr(8'h0C, 32'h0, 1'b1);
    expectIrq(3'b001, "R8 underflow beats clear");
    expectRd(8'h04, 32'd4, "R8 reload on collision");
    wr(8'h0C, 32'h1234);
    expectIrq(3'b000, "R7 clear drops irq");
    wr(8'h00, 32'd9);
    expectRd(8'h04, 32'd4, "R4 enabled load keeps counter");
    expectRd(8'h00, 32'd9, "R4 load register updated");
    wr(8'h08, 32'h48);

    // channel 2: wrap mode, slow tick, load 2
    wr(8'h28, 32'h00);
    wr(8'h20, 32'd2);
    wr(8'h28, 32'h80);
    tick(1, 3);
    expectRd(8'h24, 32'd2, "R3 fast tick ignored by slow channel");
    tick(0, 2);
    expectRd(8'h24, 32'd0, "R2 ch2 value");
    expectIrq(3'b000, "R7 ch2 quiet");
    tick(0, 1);
    expectIrq(3'b010, "R7 ch2 irq bit");
    expectRd(8'h24, 32'h0000_FFFF, "R6 16-bit wrap");
    wr(8'h24, 32'h1234);
    expectRd(8'h24, 32'h0000_FFFF, "R9 value write ignored");
    tick(0, 1);
    expectRd(8'h24, 32'h0000_FFFE, "R6 counts down after wrap");
    wr(8'h2C, 32'h0);
    expectIrq(3'b000, "R7 ch2 cleared");

    // channel 3: 32-bit
    wr(8'h88, 32'h48);
    wr(8'h80, 32'h0001_0000);
    expectRd(8'h84, 32'h0001_0000, "R4 ch3 wide copy");
    wr(8'h80, 32'd1);
    wr(8'h88, 32'hC8);
    tick(1, 2);
    expectIrq(3'b100, "R5 ch3 period 2");
    expectRd(8'h84, 32'd1, "R5 ch3 reload");
    wr(8'h88, 32'h88);
    tick(1, 2);
    expectRd(8'h84, 32'hFFFF_FFFF, "R6 32-bit wrap");
    wr(8'h8C, 32'h0);
    expectIrq(3'b000, "R7 ch3 cleared");
    expectRd(8'h40, 32'h0, "R2 unmapped reads zero");

    // free counter
    expectRd(8'h60, 32'hFFFF_FFFC, "R10 disabled holds");
    wr(8'h60, 32'h55);
    expectRd(8'h60, 32'hFFFF_FFFC, "R10 low write ignored");
    wr(8'h64, 32'h100);
    expectRd(8'h64, 32'h100, "R10 enable readback");
    tick(1, 3);
    expectRd(8'h60, 32'hFFFF_FFFF, "R10 counts fast ticks");
    expectRd(8'h64, 32'h100, "R11 no carry yet");
    tick(1, 1);
    expectRd(8'h60, 32'h0, "R11 low wraps");
    expectRd(8'h64, 32'h101, "R11 carry into high");
    tick(0, 2);
    expectRd(8'h60, 32'h0, "R10 slow tick ignored");
    wr(8'h64, 32'h0);
    expectRd(8'h64, 32'h001, "R10 disable readback");
    tick(1, 1);
    expectRd(8'h60, 32'h0, "R10 stopped");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checkCnt, errCnt);
    $finish;
  end
endmodule